// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for 32 peripheral vectors and hands the most urgent eligible one to a processor. Each vector takes its request from one of three source classes, chosen at run time: a dedicated fixed line, one of the two completion lines of the DMA channel with the same index, or a general logic signal. A level on the selected source sets the vector's pending bit. Every vector has an enable bit and a priority value whose width is a parameter (3 to 8 bits). The numerically smallest priority is the most urgent. When priorities are equal, the lowest vector number wins.

The controller registers the winning vector number, its priority and its handler address offset (0x40 + 4·n). The processor acknowledges the presented vector, which clears its pending bit and pushes its priority onto an 8-deep active stack. An end-of-handler pulse pops the stack. A configurable split divides the priority into a group part and a sub-priority part. A new request preempts a running handler only when its group is strictly more urgent. When a handler ends and an eligible request is waiting, the next vector is presented in the same cycle as the pop (tail-chaining).

Top module: `irq_prio_ctrl`

## Requirements
- R1: Per-vector source code (write data bits [1:0]) selects the request: 0 fixed line n, 1 DMA line 2n, 2 DMA line 2n+1, 3 logic line n; a level on any other line has no effect on vector n.
- R2: A selected request sets the pending bit even when the vector is disabled (write bit [2] = 0). A disabled vector is never presented. Pending bits read back at address 0x21, bit n, and in bit [3] of the vector's own word.
- R3: Among pending, enabled vectors the smallest priority (write bits [8 +: PRIO_BITS]) wins and ties go to the lowest vector number. The registered output shows the winner one cycle after the request level appears.
- R4: The presented handler offset equals 0x40 + 4 × vector number.
- R5: Acknowledging a presented vector clears its pending bit and makes its priority the active priority. An end-of-handler pulse pops back to the previous level, or to idle (active_valid low).
- R6: The split register at address 0x20 (bits [3:0], clamped to PRIO_BITS-1) gives the number of sub-priority bits. A request is presented while a handler is active only if (prio >> split) is strictly below the active group.
- R7: On end-of-handler, an eligible pending request is presented in the cycle right after the pulse, with no idle cycle in between.
- R8: The active stack holds at most 8 levels. While it is full, nothing is presented.
- R9: A priority rewritten while a request is pending is used by the next arbitration.
- R10: After reset no vector is presented, nothing is active, and all pending bits, enables and the split are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fixed_req | input | NUM_VEC | Fixed-function request lines, one per vector |
| dma_done | input | 2*NUM_VEC | Two DMA completion lines per channel |
| logic_req | input | NUM_VEC | General logic request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Register address: vectors at 0..NUM_VEC-1, split 0x20, pending 0x21 |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| irq_valid | output | 1 | A vector is presented to the processor |
| irq_vec | output | VEC_W | Presented vector number |
| irq_offset | output | 10 | Handler address offset of the presented vector |
| irq_prio | output | PRIO_BITS | Priority of the presented vector |
| irq_ack | input | 1 | Processor takes the presented vector |
| irq_eoi | input | 1 | Processor finishes the current handler |
| active_valid | output | 1 | At least one handler is active |
| active_prio | output | PRIO_BITS | Priority of the innermost active handler |

## Verification
Directed patterns drive each source class on a vector set to another class, so a wrong multiplexer leg shows up as a stray or missing pending bit. Simultaneous requests at equal and unequal priorities show whether the tie-break and the comparison direction are right. Nested sequences check three things: a same-group request with a smaller sub-priority must wait while a lower group preempts, the stack must block presentation when it is full, and the next vector must appear immediately after end-of-handler. Random rounds with a fixed seed give random sources, enables, priorities and sparse request sets. The bench drains each round one vector at a time against a reference winner, which checks arbitration order over many mixes of disabled and pending vectors.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared source-class encoding, register addresses and the handler offset
// rule for the vectored interrupt controller. Assumes at most 32 vectors.
package irq_pkg;

    typedef enum logic [1:0] {
        SRC_FIXED  = 2'd0,
        SRC_DMA_A  = 2'd1,
        SRC_DMA_B  = 2'd2,
        SRC_LOGIC  = 2'd3
    } src_sel_e;

    localparam logic [7:0] ADDR_SPLIT = 8'h20;
    localparam logic [7:0] ADDR_PEND  = 8'h21;
    localparam logic [9:0] OFS_BASE   = 10'h040;

    // Handler address offset for a vector number
    function automatic logic [9:0] vec_offset(input logic [7:0] v);
        return OFS_BASE + {v, 2'b00};
    endfunction

endpackage

// File: rtl/irq_src_sel.sv
// Module irq_src_sel
// Picks, for each vector, the request line of its configured source class
// and keeps the pending bit. Assumes level-sensitive requests; a clear from
// the acknowledge path wins over a request in the same cycle. req_eff is the
// pending state the next edge will hold, so arbitration sees a request in
// the cycle it appears.
module irq_src_sel
    import irq_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_VEC-1:0]   src_sel,
    input  logic [NUM_VEC-1:0]     fixed_req,
    input  logic [2*NUM_VEC-1:0]   dma_done,
    input  logic [NUM_VEC-1:0]     logic_req,
    input  logic [NUM_VEC-1:0]     clr_mask,
    output logic [NUM_VEC-1:0]     req_eff,
    output logic [NUM_VEC-1:0]     pending
);

    logic [NUM_VEC-1:0] sel_req;

    // One multiplexer per vector over the three source classes
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic [1:0] code;
        assign code = src_sel[2*g +: 2];
        assign sel_req[g] = (code == SRC_FIXED) ? fixed_req[g]    :
                            (code == SRC_DMA_A) ? dma_done[2*g]   :
                            (code == SRC_DMA_B) ? dma_done[2*g+1] :
                                                  logic_req[g];
    end

    assign req_eff = (pending | sel_req) & ~clr_mask;

    // Pending bits: set by a selected level, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= req_eff;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module irq_arbiter
// Combinational search for the most urgent candidate: smallest priority
// value, lowest index on a tie. Assumes candidates are already masked by
// enable and pending.
module irq_arbiter #(
    parameter int NUM_VEC   = 32,
    parameter int PRIO_BITS = 3,
    localparam int VEC_W    = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]           cand,
    input  logic [NUM_VEC*PRIO_BITS-1:0] prio_flat,
    output logic                         win_valid,
    output logic [VEC_W-1:0]             win_vec,
    output logic [PRIO_BITS-1:0]         win_prio
);

    // Ascending scan keeps the first index among equal priorities
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_prio  = '1;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (cand[i] && (!win_valid || prio_flat[i*PRIO_BITS +: PRIO_BITS] < win_prio)) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(i);
                win_prio  = prio_flat[i*PRIO_BITS +: PRIO_BITS];
            end
        end
    end

endmodule

// File: rtl/irq_prio_stack.sv
// Module irq_prio_stack
// Stack of priorities of active handlers. Besides the current top it
// offers the top as it will be after this cycle's push or pop, so the
// controller can decide eligibility for the next registered output.
// Assumes push and pop never come together and push never comes when full.
module irq_prio_stack #(
    parameter int PRIO_BITS = 3,
    parameter int DEPTH     = 8,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [PRIO_BITS-1:0] push_prio,
    input  logic                 pop,
    output logic                 top_valid,
    output logic [PRIO_BITS-1:0] top_prio,
    output logic                 nxt_valid,
    output logic [PRIO_BITS-1:0] nxt_prio,
    output logic                 nxt_full,
    output logic [CNT_W-1:0]     depth
);

    logic [PRIO_BITS-1:0] mem [DEPTH];
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     nxt_cnt;
    logic                 do_push;
    logic                 do_pop;

    assign do_push   = push && (int'(cnt) < DEPTH);
    assign do_pop    = pop && !do_push && (cnt != '0);
    assign top_valid = (cnt != '0);
    assign top_prio  = top_valid ? mem[IDX_W'(cnt - CNT_W'(1))] : '0;
    assign depth     = cnt;
    assign nxt_full  = (int'(nxt_cnt) == DEPTH);

    // Look-ahead of count and top after this cycle's operation
    always_comb begin
        nxt_cnt   = cnt;
        nxt_valid = top_valid;
        nxt_prio  = top_prio;
        if (do_push) begin
            nxt_cnt   = cnt + CNT_W'(1);
            nxt_valid = 1'b1;
            nxt_prio  = push_prio;
        end else if (do_pop) begin
            nxt_cnt   = cnt - CNT_W'(1);
            nxt_valid = (cnt > CNT_W'(1));
            nxt_prio  = (cnt > CNT_W'(1)) ? mem[IDX_W'(cnt - CNT_W'(2))] : '0;
        end
    end

    // Storage and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) mem[IDX_W'(cnt)] <= push_prio;
            cnt <= nxt_cnt;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Vectored interrupt controller top: configuration registers, source
// selection with pending bits, arbitration, group-based preemption and the
// active-priority stack. The processor acknowledges only while irq_valid is
// high and never raises irq_ack and irq_eoi in the same cycle. The priority
// pushed on acknowledge is the one presented with the vector.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_VEC     = 32,
    parameter int PRIO_BITS   = 3,
    parameter int STACK_DEPTH = 8,
    localparam int VEC_W      = $clog2(NUM_VEC),
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   fixed_req,
    input  logic [2*NUM_VEC-1:0] dma_done,
    input  logic [NUM_VEC-1:0]   logic_req,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 irq_valid,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [9:0]           irq_offset,
    output logic [PRIO_BITS-1:0] irq_prio,
    input  logic                 irq_ack,
    input  logic                 irq_eoi,
    output logic                 active_valid,
    output logic [PRIO_BITS-1:0] active_prio
);

    logic [2*NUM_VEC-1:0]         src_flat;
    logic [NUM_VEC-1:0]           en_q;
    logic [NUM_VEC*PRIO_BITS-1:0] prio_flat;
    logic [3:0]                   split_q;
    logic [NUM_VEC-1:0]           req_eff;
    logic [NUM_VEC-1:0]           pending;
    logic [NUM_VEC-1:0]           clr_mask;
    logic                         ack_take;
    logic                         vec_sel;
    logic [VEC_W-1:0]             vec_idx;
    logic                         win_valid;
    logic [VEC_W-1:0]             win_vec;
    logic [PRIO_BITS-1:0]         win_prio;
    logic                         nxt_valid;
    logic [PRIO_BITS-1:0]         nxt_prio;
    logic                         nxt_full;
    logic                         eligible;
    logic [CNT_W-1:0]             stk_depth;

    assign vec_sel  = (int'(cfg_addr) < NUM_VEC);
    assign vec_idx  = cfg_addr[VEC_W-1:0];
    assign ack_take = irq_ack && irq_valid;
    assign clr_mask = ack_take ? (NUM_VEC'(1) << irq_vec) : '0;

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_flat  <= '0;
            en_q      <= '0;
            prio_flat <= '0;
            split_q   <= '0;
        end else if (cfg_we) begin
            if (vec_sel) begin
                src_flat[2*vec_idx +: 2]               <= cfg_wdata[1:0];
                en_q[vec_idx]                          <= cfg_wdata[2];
                prio_flat[vec_idx*PRIO_BITS +: PRIO_BITS] <= cfg_wdata[8 +: PRIO_BITS];
            end else if (cfg_addr == ADDR_SPLIT) begin
                split_q <= (cfg_wdata[3:0] > 4'(PRIO_BITS - 1)) ? 4'(PRIO_BITS - 1)
                                                               : cfg_wdata[3:0];
            end
        end
    end

    // Combinational read-back
    always_comb begin
        cfg_rdata = '0;
        if (vec_sel) begin
            cfg_rdata[1:0]             = src_flat[2*vec_idx +: 2];
            cfg_rdata[2]               = en_q[vec_idx];
            cfg_rdata[3]               = pending[vec_idx];
            cfg_rdata[8 +: PRIO_BITS]  = prio_flat[vec_idx*PRIO_BITS +: PRIO_BITS];
        end else if (cfg_addr == ADDR_SPLIT) begin
            cfg_rdata[3:0] = split_q;
        end else if (cfg_addr == ADDR_PEND) begin
            cfg_rdata[NUM_VEC-1:0] = pending;
        end
    end

    irq_src_sel #(.NUM_VEC(NUM_VEC)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_flat),
        .fixed_req (fixed_req),
        .dma_done  (dma_done),
        .logic_req (logic_req),
        .clr_mask  (clr_mask),
        .req_eff   (req_eff),
        .pending   (pending)
    );

    irq_arbiter #(.NUM_VEC(NUM_VEC), .PRIO_BITS(PRIO_BITS)) u_arb (
        .cand      (req_eff & en_q),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_prio  (win_prio)
    );

    irq_prio_stack #(.PRIO_BITS(PRIO_BITS), .DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_take),
        .push_prio (irq_prio),
        .pop       (irq_eoi),
        .top_valid (active_valid),
        .top_prio  (active_prio),
        .nxt_valid (nxt_valid),
        .nxt_prio  (nxt_prio),
        .nxt_full  (nxt_full),
        .depth     (stk_depth)
    );

    // Winner may run if room remains and its group beats the next active group
    assign eligible = !nxt_full &&
                      (!nxt_valid || ((win_prio >> split_q) < (nxt_prio >> split_q)));

    // Registered presentation to the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vec    <= '0;
            irq_offset <= OFS_BASE;
            irq_prio   <= '0;
        end else begin
            irq_valid  <= win_valid && eligible;
            irq_vec    <= win_vec;
            irq_offset <= vec_offset(8'(win_vec));
            irq_prio   <= win_prio;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module irq_prio_ctrl_chk
// Assertion checker bound into irq_prio_ctrl. Observes ports plus the stack
// depth and split register; drives nothing.
module irq_prio_ctrl_chk #(
    parameter int NUM_VEC   = 32,
    parameter int PRIO_BITS = 3,
    parameter int DEPTH     = 8,
    localparam int VEC_W    = $clog2(NUM_VEC),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq_valid,
    input logic [VEC_W-1:0]     irq_vec,
    input logic [9:0]           irq_offset,
    input logic [PRIO_BITS-1:0] irq_prio,
    input logic                 irq_ack,
    input logic                 irq_eoi,
    input logic                 active_valid,
    input logic [PRIO_BITS-1:0] active_prio,
    input logic [CNT_W-1:0]     depth,
    input logic [3:0]           split
);

    // R4: offset follows the vector number
    a_r4_offset_map: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_offset == 10'(64 + 4 * int'(irq_vec))));

    // R5: acknowledge makes the presented priority active
    a_r5_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && !irq_eoi) |=> (active_valid && active_prio == $past(irq_prio)));

    // R5: popping the last level returns to idle
    a_r5_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eoi && !irq_ack && int'(depth) == 1) |=> !active_valid);

    // R6: a presented vector always beats the active group strictly
    a_r6_strict_group: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && active_valid && $stable(split)) |->
        ((irq_prio >> split) < (active_prio >> split)));

    // R8: the stack never exceeds its depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH);

    // R8: a full stack blocks presentation
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(depth) == DEPTH) |-> !irq_valid);

    // R5: processor protocol, acknowledge and end never together
    a_r5_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_eoi));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_VEC   (NUM_VEC),
    .PRIO_BITS (PRIO_BITS),
    .DEPTH     (STACK_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_valid    (irq_valid),
    .irq_vec      (irq_vec),
    .irq_offset   (irq_offset),
    .irq_prio     (irq_prio),
    .irq_ack      (irq_ack),
    .irq_eoi      (irq_eoi),
    .active_valid (active_valid),
    .active_prio  (active_prio),
    .depth        (stk_depth),
    .split        (split_q)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    localparam int NV = 32;
    localparam int PB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] fixed_req = '0;
    logic [2*NV-1:0] dma_done = '0;
    logic [NV-1:0] logic_req = '0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          irq_valid;
    logic [4:0]    irq_vec;
    logic [9:0]    irq_offset;
    logic [PB-1:0] irq_prio;
    logic          irq_ack = 1'b0;
    logic          irq_eoi = 1'b0;
    logic          active_valid;
    logic [PB-1:0] active_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]    m_src  [NV];
    logic          m_en   [NV];
    int            m_prio [NV];
    logic [NV-1:0] m_pend;

    irq_prio_ctrl #(.NUM_VEC(NV), .PRIO_BITS(PB), .STACK_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .fixed_req(fixed_req), .dma_done(dma_done),
        .logic_req(logic_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_offset(irq_offset), .irq_prio(irq_prio),
        .irq_ack(irq_ack), .irq_eoi(irq_eoi), .active_valid(active_valid),
        .active_prio(active_prio)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_vec(input int v, input logic [1:0] s, input logic e, input int p);
        wr(8'(v), (32'(p) << 8) | (32'(e) << 2) | 32'(s));
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic eoi();
        irq_eoi = 1'b1; tick(); irq_eoi = 1'b0;
    endtask

    task automatic expect_vec(input int v, input string tag);
        chk(irq_valid && irq_vec == 5'(v), tag, irq_valid ? int'(irq_vec) : -1, v);
        chk(irq_offset == 10'(64 + 4 * v), {tag, " offset R4"}, int'(irq_offset), 64 + 4 * v);
    endtask

    task automatic expect_none(input string tag);
        chk(!irq_valid, tag, int'(irq_valid), 0);
    endtask

    function automatic logic sel_line(input int v);
        case (m_src[v])
            2'd0:    return fixed_req[v];
            2'd1:    return dma_done[2*v];
            2'd2:    return dma_done[2*v+1];
            default: return logic_req[v];
        endcase
    endfunction

    function automatic int ref_winner();
        int best = -1;
        for (int v = 0; v < NV; v++)
            if (m_pend[v] && m_en[v] && (best < 0 || m_prio[v] < m_prio[best])) best = v;
        return best;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state
        expect_none("R10 no vector");
        chk(!active_valid, "R10 idle", int'(active_valid), 0);
        rd(8'h21, rv);
        chk(rv == 0, "R10 pending clear", int'(rv), 0);
        rd(8'h20, rv);
        chk(rv == 0, "R10 split clear", int'(rv), 0);

        // R1: vector 5 on DMA line 2n (code 1); line 2n+1 has no effect
        set_vec(5, 2'd1, 1'b1, 3);
        dma_done[11] = 1'b1; fixed_req[5] = 1'b1; logic_req[5] = 1'b1;
        tick();
        dma_done = '0; fixed_req = '0; logic_req = '0;
        expect_none("R1 other lines ignored");
        rd(8'h21, rv);
        chk(rv[5] == 1'b0, "R1 no pending", int'(rv[5]), 0);
        dma_done[10] = 1'b1;
        tick();
        dma_done = '0;
        expect_vec(5, "R1 selected DMA line");
        ack();
        chk(active_valid && active_prio == 4'd3, "R5 active after ack", int'(active_prio), 3);
        rd(8'd5, rv);
        chk(rv[3] == 1'b0, "R5 pending cleared", int'(rv[3]), 0);
        eoi();
        chk(!active_valid, "R5 idle after eoi", int'(active_valid), 0);

        // R2: disabled vector becomes pending but is not presented
        set_vec(7, 2'd3, 1'b0, 2);
        logic_req[7] = 1'b1;
        tick();
        logic_req = '0;
        expect_none("R2 disabled not presented");
        rd(8'h21, rv);
        chk(rv[7] == 1'b1, "R2 pending held", int'(rv[7]), 1);
        set_vec(7, 2'd3, 1'b1, 2);
        tick();
        expect_vec(7, "R2 presented once enabled");
        ack(); eoi();

        // R3: tie goes to lower index, lower value beats index
        set_vec(9, 2'd0, 1'b1, 6);
        set_vec(3, 2'd0, 1'b1, 6);
        set_vec(20, 2'd0, 1'b1, 2);
        fixed_req[9] = 1'b1; fixed_req[3] = 1'b1;
        tick();
        fixed_req = '0;
        expect_vec(3, "R3 tie lowest index");
        fixed_req[20] = 1'b1;
        tick();
        fixed_req = '0;
        expect_vec(20, "R3 smaller value wins");
        ack();
        expect_none("R6 no preempt by less urgent");
        eoi();
        expect_vec(3, "R7 tail chain after eoi");
        ack(); eoi();
        expect_vec(9, "R7 tail chain second");
        ack(); eoi();
        expect_none("R3 all drained");

        // R9: runtime priority change used next arbitration
        set_vec(12, 2'd0, 1'b1, 9);
        set_vec(13, 2'd0, 1'b1, 8);
        fixed_req[12] = 1'b1; fixed_req[13] = 1'b1;
        tick();
        fixed_req = '0;
        expect_vec(13, "R9 before change");
        set_vec(12, 2'd0, 1'b1, 5);
        tick();
        expect_vec(12, "R9 after change");
        ack(); eoi();
        ack(); eoi();

        // R6: group split of 2 bits, sub-priority does not preempt
        wr(8'h20, 32'd2);
        rd(8'h20, rv);
        chk(rv == 2, "R6 split readback", int'(rv), 2);
        set_vec(1, 2'd0, 1'b1, 9);
        fixed_req[1] = 1'b1; tick(); fixed_req = '0;
        ack();
        set_vec(2, 2'd0, 1'b1, 8);
        fixed_req[2] = 1'b1; tick(); fixed_req = '0;
        expect_none("R6 same group waits");
        set_vec(4, 2'd0, 1'b1, 7);
        fixed_req[4] = 1'b1; tick(); fixed_req = '0;
        expect_vec(4, "R6 lower group preempts");
        ack();
        chk(active_prio == 4'd7, "R6 nested active", int'(active_prio), 7);
        eoi();
        chk(active_valid && active_prio == 4'd9, "R5 pop to previous", int'(active_prio), 9);
        expect_none("R6 still same group");
        eoi();
        expect_vec(2, "R7 tail chain after group end");
        ack(); eoi();
        wr(8'h20, 32'd15);
        rd(8'h20, rv);
        chk(rv == PB - 1, "R6 split clamp", int'(rv), PB - 1);
        wr(8'h20, 32'd0);

        // R8: fill the stack with 8 nested levels
        for (int i = 0; i < 8; i++) begin
            set_vec(16 + i, 2'd0, 1'b1, 15 - i);
            fixed_req[16 + i] = 1'b1; tick(); fixed_req = '0;
            expect_vec(16 + i, "R8 nesting");
            ack();
        end
        set_vec(24, 2'd0, 1'b1, 0);
        fixed_req[24] = 1'b1; tick(); fixed_req = '0;
        expect_none("R8 full blocks");
        eoi();
        expect_vec(24, "R8 room after pop");
        ack();
        for (int i = 0; i < 8; i++) eoi();
        chk(!active_valid, "R8 unwound", int'(active_valid), 0);

        // R3 random rounds against a reference winner
        rd(8'h21, rv);
        chk(rv == 0, "R2 no stale pending", int'(rv), 0);
        m_pend = '0;
        for (int r = 0; r < 40; r++) begin
            for (int v = 0; v < NV; v++) begin
                m_src[v]  = 2'($urandom_range(0, 3));
                m_en[v]   = ($urandom_range(0, 3) != 0);
                m_prio[v] = $urandom_range(0, 15);
                set_vec(v, m_src[v], m_en[v], m_prio[v]);
            end
            fixed_req = $urandom & $urandom;
            dma_done  = {$urandom & $urandom, $urandom & $urandom};
            logic_req = $urandom & $urandom;
            for (int v = 0; v < NV; v++) if (sel_line(v)) m_pend[v] = 1'b1;
            tick();
            fixed_req = '0; dma_done = '0; logic_req = '0;
            for (int k = 0; k < NV + 1; k++) begin
                int w;
                w = ref_winner();
                if (w < 0) break;
                expect_vec(w, "R3 random order");
                ack();
                m_pend[w] = 1'b0;
                eoi();
            end
            expect_none("R2 random disabled left");
            rd(8'h21, rv);
            chk(rv == m_pend, "R1 random pending set", int'(rv), int'(m_pend));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule